// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block takes an SDRAM device from reset to a usable state. Once reset is released it keeps the clock enable high and presents only no-operation commands while a stabilisation interval counts down. The interval is given in microseconds and converted to clocks from a clock-frequency parameter. After that it closes every bank with a precharge-all command and issues a configurable number of auto-refresh commands, never fewer than two. It also writes the mode register with a value taken from an input, clearing the bits that must be zero. Each command is followed by the spacing the device needs before the next one: tRP clocks after the precharge, tRC clocks after each refresh, and tMRD clocks after the mode write.

An elaboration-time parameter chooses whether the refreshes come before or after the mode write. When the last recovery interval has ended, `init_done` goes high and stays high until the next reset, and the bus stays at no-operation. The command controller downstream takes over from that point. A reset at any time, even in a cycle that issues a command, aborts the sequence and starts it again from the stabilisation wait.

The controller has these states: ST_STABLE (the stabilisation wait), ST_PALL, ST_WAIT_RP, ST_REF, ST_WAIT_RC, ST_MRS, ST_WAIT_MRD and ST_DONE. The transitions are:
- ST_STABLE to ST_PALL when the wait timer ends.
- ST_PALL to ST_WAIT_RP.
- ST_WAIT_RP to ST_REF, or to ST_MRS when MRS_FIRST is set, when the timer ends.
- ST_REF to ST_WAIT_RC.
- ST_WAIT_RC back to ST_REF while refreshes remain. Otherwise it goes to ST_MRS, or to ST_DONE when MRS_FIRST is set.
- ST_MRS to ST_WAIT_MRD.
- ST_WAIT_MRD to ST_DONE, or to ST_REF when MRS_FIRST is set.
- ST_DONE holds.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is low and for WAIT_US*CLK_MHZ clocks after its release, `cke` is 1, the command bus {cs_n,ras_n,cas_n,we_n} is 4'b0111 (no-operation) and `init_done` is 0.
- R2: The first command is precharge-all, encoded 4'b0010, with `addr` bit 10 set, every other `addr` bit 0 and `ba` 0. It appears in the cycle that follows the stabilisation interval, which is cycle WAIT_US*CLK_MHZ counted from reset release.
- R3: Exactly max(N_REFRESH,2) auto-refresh commands are issued, each encoded 4'b0001.
- R4: The next command follows precharge-all after T_RP clocks and follows each refresh after T_RC clocks. The bus is no-operation in between, so two commands never come in adjacent cycles.
- R5: The mode write is encoded 4'b0000 with `ba` 0. It drives `addr` with `mode_cfg`, but bits 7, 8 and 10 (and any bit above 10) are forced to 0, so only bits 0-6 and 9 pass through.
- R6: With MRS_FIRST=0 the refreshes precede the mode write. With MRS_FIRST=1 the mode write comes T_RP after the precharge and the first refresh comes T_MRD after the mode write.
- R7: `init_done` rises T_MRD clocks after the mode write (MRS_FIRST=0), or T_RC clocks after the last refresh (MRS_FIRST=1). It then stays high, and the bus stays at no-operation, until reset.
- R8: An asynchronous reset, even one that lands in a command cycle, forces no-operation and `init_done` low at once. After release, the whole sequence restarts from the stabilisation wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cfg | input | ADDR_W | Value to load into the mode register |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (bit 10 selects all banks on precharge) |
| ba | output | BA_W | Bank address |
| init_done | output | 1 | Sequence complete, sticky until reset |

## Verification
Reset assertion and command issue can fall in the same cycle, and that collision is where the sequence is most exposed. The bench waits for the clock edge that moves the second instance into its second refresh and drops reset one time step later, inside that command cycle. The result is judged as follows:
- The aborted refresh must never be seen on the bus.
- The outputs must read no-operation with `init_done` low while reset is held.
- The next run must replay the full sequence from the stabilisation wait, with the same cycle offsets and with a new mode value masked as specified.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_PALL,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RC,
        ST_MRS,
        ST_WAIT_MRD,
        ST_DONE
    } init_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS  = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PALL = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdram_cmd_e;

    // Bit position of the all-banks flag on precharge
    localparam int ALLBANK_BIT = 10;

    // Mode bits that pass through: burst length/type, latency, write burst mode
    function automatic bit mode_bit_kept(input int idx);
        return (idx <= 6) || (idx == 9);
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         en,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (en) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = en && (cnt_q == W'(1));

    // A counting phase never starts from an empty count
    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q != '0)); // R4

endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
    parameter int W     = 2,
    parameter int COUNT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  logic dec,
    output logic none_left
);

    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (ld) begin
            left_q <= W'(COUNT);
        end else if (dec) begin
            left_q <= left_q - W'(1);
        end
    end

    assign none_left = (left_q == '0);

    AST_REF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (left_q != '0)); // R3

    AST_REF_LD_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld && dec)); // R3

endmodule

// File: rtl/sdram_init_cmdenc.sv
module sdram_init_cmdenc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BA_W   = 2
) (
    input  init_state_e       state,
    input  logic [ADDR_W-1:0] mode_cfg,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] allbank_addr;
    sdram_cmd_e        cmd;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign keep_mask[i]    = mode_bit_kept(i) ? 1'b1 : 1'b0;
        assign allbank_addr[i] = (i == ALLBANK_BIT) ? 1'b1 : 1'b0;
    end

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state)
            ST_PALL: begin
                cmd  = CMD_PALL;
                addr = allbank_addr;
            end
            ST_REF: begin
                cmd = CMD_REF;
            end
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = mode_cfg & keep_mask;
            end
            ST_STABLE, ST_WAIT_RP, ST_WAIT_RC, ST_WAIT_MRD, ST_DONE: begin
                cmd = CMD_NOP;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int BA_W      = 2,
    parameter int CLK_MHZ   = 125,
    parameter int WAIT_US   = 200,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_MRD     = 2,
    parameter int N_REFRESH = 2,
    parameter bit MRS_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mode_cfg,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba,
    output logic              init_done
);

    localparam int WAIT_CYC = (CLK_MHZ * WAIT_US < 1) ? 1 : CLK_MHZ * WAIT_US;
    localparam int RP_EFF   = (T_RP  < 2) ? 2 : T_RP;
    localparam int RC_EFF   = (T_RC  < 2) ? 2 : T_RC;
    localparam int MRD_EFF  = (T_MRD < 2) ? 2 : T_MRD;
    localparam int N_EFF    = (N_REFRESH < 2) ? 2 : N_REFRESH;
    localparam int GAP_MAX  = (RC_EFF > RP_EFF) ?
                              ((RC_EFF > MRD_EFF) ? RC_EFF : MRD_EFF) :
                              ((RP_EFF > MRD_EFF) ? RP_EFF : MRD_EFF);
    localparam int CNT_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
    localparam int TW       = $clog2(CNT_MAX + 1);
    localparam int RW       = $clog2(N_EFF + 1);

    init_state_e   state_q, state_d;
    logic          tmr_ld, tmr_en, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          ref_ld, ref_dec, ref_none;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STABLE:   if (tmr_exp) state_d = ST_PALL;
            ST_PALL:     state_d = ST_WAIT_RP;
            ST_WAIT_RP:  if (tmr_exp) state_d = MRS_FIRST ? ST_MRS : ST_REF;
            ST_REF:      state_d = ST_WAIT_RC;
            ST_WAIT_RC: begin
                if (tmr_exp) begin
                    if (!ref_none)     state_d = ST_REF;
                    else if (MRS_FIRST) state_d = ST_DONE;
                    else               state_d = ST_MRS;
                end
            end
            ST_MRS:      state_d = ST_WAIT_MRD;
            ST_WAIT_MRD: if (tmr_exp) state_d = MRS_FIRST ? ST_REF : ST_DONE;
            ST_DONE:     state_d = ST_DONE;
            default:     state_d = ST_STABLE;
        endcase
    end

    // Control outputs per state
    always_comb begin
        tmr_ld    = 1'b0;
        tmr_en    = 1'b0;
        tmr_val   = '0;
        ref_ld    = 1'b0;
        ref_dec   = 1'b0;
        init_done = 1'b0;
        unique case (state_q)
            ST_STABLE, ST_WAIT_RP, ST_WAIT_RC, ST_WAIT_MRD: tmr_en = 1'b1;
            ST_PALL: begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(RP_EFF - 1);
                ref_ld  = 1'b1;
            end
            ST_REF: begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(RC_EFF - 1);
                ref_dec = 1'b1;
            end
            ST_MRS: begin
                tmr_ld  = 1'b1;
                tmr_val = TW'(MRD_EFF - 1);
            end
            ST_DONE: init_done = 1'b1;
            default: begin
                tmr_en = 1'b0;
            end
        endcase
    end

    assign cke = 1'b1;

    sdram_init_timer #(
        .W       (TW),
        .RST_VAL (WAIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (tmr_ld),
        .ld_val  (tmr_val),
        .en      (tmr_en),
        .expired (tmr_exp)
    );

    sdram_init_refcnt #(
        .W     (RW),
        .COUNT (N_EFF)
    ) u_refcnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ref_ld),
        .dec       (ref_dec),
        .none_left (ref_none)
    );

    sdram_init_cmdenc #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_cmdenc (
        .state    (state_q),
        .mode_cfg (mode_cfg),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .addr     (addr),
        .ba       (ba)
    );

    // Observation of the command bus for the properties below
    logic [3:0]    bus;
    logic          cmd_seen_q;
    logic [RW-1:0] ref_tally_q;
    logic [ADDR_W-1:0] rsv_bits;

    assign bus = {cs_n, ras_n, cas_n, we_n};

    for (genvar j = 0; j < ADDR_W; j++) begin : g_rsv
        assign rsv_bits[j] = mode_bit_kept(j) ? 1'b0 : addr[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_seen_q  <= 1'b0;
            ref_tally_q <= '0;
        end else begin
            if (bus != CMD_NOP) cmd_seen_q <= 1'b1;
            if (bus == CMD_REF) ref_tally_q <= ref_tally_q + RW'(1);
        end
    end

    AST_CMD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus != CMD_NOP) |=> (bus == CMD_NOP)); // R4

    AST_FIRST_IS_PALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus != CMD_NOP) && !cmd_seen_q) |-> (bus == CMD_PALL)); // R2

    AST_MRS_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus == CMD_MRS) |-> ((rsv_bits == '0) && (ba == '0))); // R5

    AST_REF_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (ref_tally_q == RW'(N_EFF))); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R7

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (bus == CMD_NOP)); // R7

endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

    localparam int AW = 11;

    typedef struct {
        int            cyc;
        int            kind;
        logic [AW-1:0] addr;
    } item_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          rst0_n, rst1_n;
    logic [AW-1:0] mode0, mode1;
    logic          cke0, cs0, ras0, cas0, we0, done0;
    logic          cke1, cs1, ras1, cas1, we1, done1;
    logic [AW-1:0] addr0, addr1;
    logic [1:0]    ba0, ba1;

    sdram_init_seq u0 (
        .clk(clk), .rst_n(rst0_n), .mode_cfg(mode0), .cke(cke0),
        .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0),
        .addr(addr0), .ba(ba0), .init_done(done0)
    );

    sdram_init_seq #(
        .WAIT_US(2), .T_RP(2), .T_RC(4), .N_REFRESH(3), .MRS_FIRST(1'b1)
    ) u1 (
        .clk(clk), .rst_n(rst1_n), .mode_cfg(mode1), .cke(cke1),
        .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1),
        .addr(addr1), .ba(ba1), .init_done(done1)
    );

    item_t q0[$];
    item_t q1[$];
    int n_chk = 0;
    int n_fail = 0;
    int cyc0, cyc1;
    logic pd0, pd1;

    always @(posedge clk or negedge rst0_n)
        if (!rst0_n) cyc0 <= 0; else cyc0 <= cyc0 + 1;
    always @(posedge clk or negedge rst1_n)
        if (!rst1_n) cyc1 <= 0; else cyc1 <= cyc1 + 1;

    // kinds: 0 NOP, 1 precharge-all, 2 refresh, 3 mode write, 4 done, 9 illegal
    function automatic int kind_of(input logic [3:0] b);
        case (b)
            4'b0111: return 0;
            4'b0010: return 1;
            4'b0001: return 2;
            4'b0000: return 3;
            default: return 9;
        endcase
    endfunction

    task automatic check(input string req, input bit ok, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic push(input int which, input int c, input int k, input logic [AW-1:0] a);
        item_t it;
        it.cyc = c; it.kind = k; it.addr = a;
        if (which == 0) q0.push_back(it); else q1.push_back(it);
    endtask

    task automatic push_mrs_first_run(input logic [AW-1:0] m);
        push(1, 250, 1, 11'h400);
        push(1, 252, 3, m);
        push(1, 254, 2, '0);
        push(1, 258, 2, '0);
        push(1, 262, 2, '0);
        push(1, 266, 4, '0);
    endtask

    // Scoreboard compare of one observed event
    task automatic mon(input int which, input int cyc, input int k,
                       input logic [AW-1:0] a, input logic [1:0] b);
        item_t it;
        string req;
        if ((which == 0 && q0.size() == 0) || (which == 1 && q1.size() == 0)) begin
            check("R7", 1'b0, "unexpected event kind", k, 0);
            return;
        end
        it = (which == 0) ? q0.pop_front() : q1.pop_front();
        req = (which == 1) ? "R6" : (it.kind == 1) ? "R2" : (it.kind == 2) ? "R3" :
              (it.kind == 3) ? "R5" : "R7";
        check(req, k == it.kind, "event kind", k, it.kind);
        check((it.kind == 4) ? "R7" : "R4", cyc == it.cyc, "event cycle", cyc, it.cyc);
        if (k == 1 || k == 3) begin
            check((k == 1) ? "R2" : "R5", a == it.addr, "addr", int'(a), int'(it.addr));
            check((k == 1) ? "R2" : "R5", b == 2'b00, "ba", int'(b), 0);
        end
    endtask

    always @(negedge clk) begin
        if (!rst0_n) begin
            pd0 <= 1'b0;
        end else begin
            if (kind_of({cs0, ras0, cas0, we0}) != 0)
                mon(0, cyc0, kind_of({cs0, ras0, cas0, we0}), addr0, ba0);
            if (done0 && !pd0) mon(0, cyc0, 4, '0, 2'b00);
            if (pd0 && !done0) check("R7", 1'b0, "done dropped", 0, 1);
            pd0 <= done0;
        end
        if (!rst1_n) begin
            pd1 <= 1'b0;
        end else begin
            if (kind_of({cs1, ras1, cas1, we1}) != 0)
                mon(1, cyc1, kind_of({cs1, ras1, cas1, we1}), addr1, ba1);
            if (done1 && !pd1) mon(1, cyc1, 4, '0, 2'b00);
            if (pd1 && !done1) check("R7", 1'b0, "done dropped", 0, 1);
            pd1 <= done1;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        check("R7", 1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        rst0_n = 1'b0;
        rst1_n = 1'b0;
        mode0  = 11'h5A5;
        mode1  = 11'h032;

        // u0: refresh-first, 25000-cycle wait, tRP 3, tRC 9, tMRD 2
        push(0, 25000, 1, 11'h400);
        push(0, 25003, 2, '0);
        push(0, 25012, 2, '0);
        push(0, 25021, 3, 11'h025);   // 0x5A5 with bits 7,8,10 cleared
        push(0, 25023, 4, '0);
        // u1: mode-first, 250-cycle wait, three refreshes
        push_mrs_first_run(11'h032);

        repeat (3) @(negedge clk);
        check("R1", cke0 == 1'b1, "cke in reset", int'(cke0), 1);
        check("R1", kind_of({cs0, ras0, cas0, we0}) == 0, "cmd in reset",
              kind_of({cs0, ras0, cas0, we0}), 0);
        check("R1", done0 == 1'b0, "done in reset", int'(done0), 0);
        rst0_n = 1'b1;
        rst1_n = 1'b1;

        fork
            begin
                while (cyc0 != 24999) @(negedge clk);
                check("R1", kind_of({cs0, ras0, cas0, we0}) == 0 && cke0,
                      "last wait cycle not idle", kind_of({cs0, ras0, cas0, we0}), 0);
                check("R1", done0 == 1'b0, "done during wait", int'(done0), 0);
                wait (done0);
                repeat (50) @(negedge clk);
                check("R7", done0 == 1'b1, "done held", int'(done0), 1);
            end
            begin
                wait (done1);
                repeat (5) @(negedge clk);
                // Run 2: reset lands in the cycle of the second refresh
                push(1, 250, 1, 11'h400);
                push(1, 252, 3, 11'h032);
                push(1, 254, 2, '0);
                rst1_n = 1'b0;
                @(negedge clk);
                rst1_n = 1'b1;
                do begin
                    @(posedge clk);
                    #1;
                end while (cyc1 != 258);
                rst1_n = 1'b0;
                @(negedge clk);
                check("R8", kind_of({cs1, ras1, cas1, we1}) == 0,
                      "cmd after reset collision", kind_of({cs1, ras1, cas1, we1}), 0);
                check("R8", done1 == 1'b0, "done after reset collision", int'(done1), 0);
                check("R8", cke1 == 1'b1, "cke after reset collision", int'(cke1), 1);
                // Run 3: full restart, reserved mode bits all set on input
                mode1 = 11'h7FF;
                push_mrs_first_run(11'h27F);
                @(negedge clk);
                rst1_n = 1'b1;
                wait (done1);
                repeat (20) @(negedge clk);
            end
        join

        check("R3", q0.size() == 0, "u0 events missing", q0.size(), 0);
        check("R8", q1.size() == 0, "u1 events missing", q1.size(), 0);
        summary();
    end

endmodule